// File: doc/BRIEF.md
# Program Suspend and Resume Controller

This controller sits between the host command decoder and the internal write state machine (WSM) that programs a fixed run of words. A program command starts an operation at a given address. The controller then advances the address and a progress count on each checkpoint pulse from the WSM. A suspend command is accepted at any address while the operation runs. It only takes effect at the next checkpoint, and the controller reports it on the status byte.

While suspended, the controller accepts only the four read-mode commands and resume. Resume restarts the WSM from the saved address and count, so words already written are not written again. An erase-suspended flag comes in from outside. A program started while an erase is suspended can itself be suspended, which gives the nested state.

Top module: `prog_susp_ctrl`

## Requirements
- R1: After reset: status_o is 0x80 with erase_susp_i low, rd_mode_o is 0 (array), wsm_run_o is 0, and wsm_addr_o and wsm_cnt_o are 0. Read mode codes are 0 array, 1 status, 2 identifier, 3 query table.
- R2: In idle, the program command (code 0x10) loads wsm_addr_o from cmd_addr_i and clears wsm_cnt_o. It raises wsm_run_o, clears status bit 7 and selects read mode 1, all visible after the clock edge that samples the command.
- R3: While running, each wsm_ckpt_i pulse advances wsm_addr_o and wsm_cnt_o by one. The pulse that brings wsm_cnt_o to PROG_WORDS ends the operation: wsm_run_o drops and status bit 7 sets.
- R4: The suspend command (code 0x20) is accepted at any cmd_addr_i while running. It takes effect only at the next wsm_ckpt_i pulse, and never on the edge that samples it. Until then wsm_run_o stays 1 and status bits 7 and 2 stay clear. The pending time must stay within MAX_LAT cycles.
- R5: Once suspended, status bits 7 and 2 are both set, wsm_run_o is 0, and wsm_addr_o and wsm_cnt_o hold their values.
- R6: While suspended, codes 0x01, 0x02, 0x03 and 0x04 select read modes 0, 1, 2 and 3.
- R7: While suspended, every other code except resume is ignored, including program, a second suspend and 0x30. Read mode, status, address and count stay unchanged.
- R8: While suspended, resume (code 0x21) clears status bits 2 and 7, raises wsm_run_o and selects read mode 1. The operation continues from the held address and count and ends after the remaining checkpoints.
- R9: If a suspend is pending when the checkpoint for the final word arrives, the operation completes and the controller goes idle, not suspended.
- R10: Status bit 6 follows erase_susp_i. A program started while erase_susp_i is high can be suspended, giving status 0xC4. Resume then leaves only bit 6 set.
- R11: Asserting rst_ni low while suspended immediately abandons the operation and returns every output to its R1 value.
- R12: In idle, codes 0x01 to 0x04 select the read mode, and suspend and resume have no effect on status, wsm_run_o or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| cmd_addr_i | input | AW | Command address; start address for program |
| wsm_ckpt_i | input | 1 | Checkpoint pulse from the WSM, one per finished word |
| erase_susp_i | input | 1 | An erase is currently suspended |
| wsm_run_o | output | 1 | WSM is allowed to program |
| wsm_addr_o | output | AW | Address of the next word to program |
| wsm_cnt_o | output | CW | Words already programmed |
| rd_mode_o | output | 2 | Selected read mode |
| status_o | output | 8 | Status: bit 7 ready, bit 6 erase suspended, bit 2 program suspended |

## Verification
Every command and checkpoint result is registered once, so it is due on the first rising edge after the stimulus is presented. The bench drives inputs on the falling edge and compares outputs on the next falling edge. The exception is reset, which is asynchronous: the bench checks it one time unit after rst_ni falls, with no clock edge in between. The pending-suspend window is stretched over zero to two idle cycles before the checkpoint, and status is checked in each of those cycles to show that suspension has not yet happened.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PEND, ST_SUSP} st_e;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID, RM_QUERY} rmode_e;

  localparam logic [7:0] OP_RD_ARRAY = 8'h01;
  localparam logic [7:0] OP_RD_STAT  = 8'h02;
  localparam logic [7:0] OP_RD_ID    = 8'h03;
  localparam logic [7:0] OP_RD_QUERY = 8'h04;
  localparam logic [7:0] OP_PROG     = 8'h10;
  localparam logic [7:0] OP_SUSP     = 8'h20;
  localparam logic [7:0] OP_RESUME   = 8'h21;

  typedef struct packed {
    logic   start;
    logic   susp;
    logic   resume;
    logic   set_mode;
    rmode_e mode;
  } cmd_act_t;
endpackage

// File: rtl/psr_cmd_filter.sv
module psr_cmd_filter
  import psr_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] code_i,
  input  st_e        st_i,
  output cmd_act_t   act_o
);
  logic rd_ok;
  assign rd_ok = (st_i == ST_IDLE) || (st_i == ST_SUSP);

  always_comb begin
    act_o = '0;
    if (valid_i) begin
      unique case (code_i)
        OP_RD_ARRAY: begin act_o.set_mode = rd_ok; act_o.mode = RM_ARRAY; end
        OP_RD_STAT:  begin act_o.set_mode = rd_ok; act_o.mode = RM_STATUS; end
        OP_RD_ID:    begin act_o.set_mode = rd_ok; act_o.mode = RM_ID; end
        OP_RD_QUERY: begin act_o.set_mode = rd_ok; act_o.mode = RM_QUERY; end
        OP_PROG:     act_o.start  = (st_i == ST_IDLE);
        OP_SUSP:     act_o.susp   = (st_i == ST_RUN);
        OP_RESUME:   act_o.resume = (st_i == ST_SUSP);
        default:     act_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/psr_prog_tracker.sv
module psr_prog_tracker #(
  parameter int AW         = 8,
  parameter int PROG_WORDS = 4,
  localparam int CW        = $clog2(PROG_WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(PROG_WORDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
    end else if (load_i) begin
      addr_o <= base_i;
      cnt_o  <= '0;
    end else if (step_i) begin
      addr_o <= addr_o + 1'b1;
      cnt_o  <= cnt_o + 1'b1;
    end
  end

  assign last_o = (cnt_o == LAST);

  // R3
  step_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_o < CW'(PROG_WORDS)));
endmodule

// File: rtl/prog_susp_ctrl.sv
module prog_susp_ctrl
  import psr_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PROG_WORDS = 4,
  parameter int MAX_LAT    = 16,
  localparam int CW        = $clog2(PROG_WORDS + 1),
  localparam int LW        = $clog2(MAX_LAT + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_code_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic          wsm_ckpt_i,
  input  logic          erase_susp_i,
  output logic          wsm_run_o,
  output logic [AW-1:0] wsm_addr_o,
  output logic [CW-1:0] wsm_cnt_o,
  output logic [1:0]    rd_mode_o,
  output logic [7:0]    status_o
);
  st_e      st_q, st_d;
  rmode_e   mode_q, mode_d;
  cmd_act_t act;
  logic     step, last;

  psr_cmd_filter u_filter (
    .valid_i (cmd_valid_i),
    .code_i  (cmd_code_i),
    .st_i    (st_q),
    .act_o   (act)
  );

  assign step = wsm_ckpt_i && (st_q == ST_RUN || st_q == ST_PEND);

  psr_prog_tracker #(.AW(AW), .PROG_WORDS(PROG_WORDS)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (act.start),
    .base_i (cmd_addr_i),
    .step_i (step),
    .addr_o (wsm_addr_o),
    .cnt_o  (wsm_cnt_o),
    .last_o (last)
  );

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    if (act.set_mode) mode_d = act.mode;
    unique case (st_q)
      ST_IDLE: if (act.start) begin st_d = ST_RUN; mode_d = RM_STATUS; end
      ST_RUN: begin
        if (step && last)  st_d = ST_IDLE;
        else if (act.susp) begin st_d = ST_PEND; mode_d = RM_STATUS; end
      end
      ST_PEND: begin
        if (step && last) st_d = ST_IDLE;
        else if (step)    st_d = ST_SUSP;
      end
      ST_SUSP: if (act.resume) begin st_d = ST_RUN; mode_d = RM_STATUS; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= RM_ARRAY;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
    end
  end

  assign wsm_run_o = (st_q == ST_RUN) || (st_q == ST_PEND);
  assign rd_mode_o = mode_q;
  assign status_o  = {(st_q == ST_IDLE) || (st_q == ST_SUSP), erase_susp_i,
                      3'b000, st_q == ST_SUSP, 2'b00};

  // pending-suspend latency monitor
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lat_q <= '0;
    else if (st_q != ST_PEND)      lat_q <= '0;
    else if (lat_q != '1)          lat_q <= lat_q + 1'b1;
  end

  // R4
  latency_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q <= LW'(MAX_LAT));
  // R4
  no_early_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && act.susp) |=> !status_o[2]);
  // R4
  susp_at_ckpt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> $past(wsm_ckpt_i));
  // R5
  held_in_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP) |=> ($stable(wsm_addr_o) && $stable(wsm_cnt_o)));
  // R8
  resume_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SUSP && act.resume) |=> (wsm_run_o && !status_o[2] && !status_o[7]));
endmodule

// File: tb/tb_prog_susp_ctrl.sv
module tb_prog_susp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int PW = 4;
  localparam int CW = $clog2(PW + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, ckpt = 1'b0, esus = 1'b0;
  logic [7:0] code = '0;
  logic [AW-1:0] caddr = '0;
  logic run;
  logic [AW-1:0] waddr;
  logic [CW-1:0] wcnt;
  logic [1:0] mode;
  logic [7:0] stat;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_susp_ctrl #(.AW(AW), .PROG_WORDS(PW), .MAX_LAT(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_code_i(code),
    .cmd_addr_i(caddr), .wsm_ckpt_i(ckpt), .erase_susp_i(esus),
    .wsm_run_o(run), .wsm_addr_o(waddr), .wsm_cnt_o(wcnt),
    .rd_mode_o(mode), .status_o(stat));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmd(logic [7:0] c, logic [AW-1:0] a);
    cmd_valid = 1'b1; code = c; caddr = a;
    @(negedge clk);
    cmd_valid = 1'b0; code = 8'h00;
  endtask

  task automatic pulse();
    ckpt = 1'b1;
    @(negedge clk);
    ckpt = 1'b0;
  endtask

  task automatic idle_check(string req, int es);
    chk(req, stat, 32'h80 | (es << 6));
    chk(req, run, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    idle_check("R1", 0);
    chk("R1", mode, 0); chk("R1", waddr, 0); chk("R1", wcnt, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 idle: suspend/resume no effect, read modes selectable
    cmd(8'h20, 8'h33); idle_check("R12", 0); chk("R12", waddr, 0);
    cmd(8'h21, 8'h00); idle_check("R12", 0); chk("R12", wcnt, 0);
    for (int m = 1; m <= 4; m++) begin
      cmd(8'(m), 8'h00); chk("R12", mode, m - 1);
    end
    cmd(8'h01, 8'h00);

    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < PW; k++) begin
        for (int d = 0; d < 3; d++) begin
          for (int es = 0; es < 2; es++) begin
            logic [AW-1:0] base;
            base = AW'(b * 77 + 5);
            esus = es[0];
            cmd(8'h10, base);
            // R2
            chk("R2", run, 1); chk("R2", waddr, base); chk("R2", wcnt, 0);
            chk("R2", stat, es << 6); chk("R2", mode, 1);
            for (int i = 0; i < k; i++) pulse();
            // R3
            chk("R3", waddr, AW'(base + k)); chk("R3", wcnt, k);
            cmd(8'h20, AW'(~base + d));
            // R4 not yet suspended
            chk("R4", run, 1); chk("R4", stat, es << 6); chk("R4", mode, 1);
            for (int i = 0; i < d; i++) begin
              @(negedge clk);
              chk("R4", stat, es << 6); chk("R4", run, 1);
            end
            pulse();
            if (k == PW - 1) begin
              // R9 final checkpoint wins over pending suspend
              idle_check("R9", es); chk("R9", wcnt, PW);
              chk("R9", waddr, AW'(base + PW));
            end else begin
              // R5 / R10
              chk("R5", stat, 32'h84 | (es << 6)); chk("R5", run, 0);
              chk("R5", waddr, AW'(base + k + 1)); chk("R5", wcnt, k + 1);
              if (es == 1) chk("R10", stat, 32'hC4);
              // R7 ignored codes
              cmd(8'h10, 8'h99); cmd(8'h20, 8'h00); cmd(8'h30, 8'h12);
              cmd(8'hFF, 8'h00); pulse();
              chk("R7", stat, 32'h84 | (es << 6)); chk("R7", mode, 1);
              chk("R7", waddr, AW'(base + k + 1)); chk("R7", wcnt, k + 1);
              chk("R7", run, 0);
              // R6 read modes
              for (int m = 1; m <= 4; m++) begin
                cmd(8'(m), 8'h00); chk("R6", mode, m - 1);
                chk("R6", stat, 32'h84 | (es << 6));
              end
              // R8 resume
              cmd(8'h21, 8'h00);
              chk("R8", run, 1); chk("R8", stat, es << 6); chk("R8", mode, 1);
              chk("R8", waddr, AW'(base + k + 1)); chk("R8", wcnt, k + 1);
              if (es == 1) chk("R10", stat, 32'h40);
              for (int i = k + 1; i < PW; i++) pulse();
              idle_check("R8", es); chk("R8", wcnt, PW);
              chk("R3", waddr, AW'(base + PW));
            end
          end
        end
      end
    end

    // R11 async reset while suspended
    esus = 1'b0;
    cmd(8'h10, 8'h40); pulse(); cmd(8'h20, 8'h00); pulse();
    cmd(8'h03, 8'h00);
    chk("R11", stat, 32'h84);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    idle_check("R11", 0);
    chk("R11", mode, 0); chk("R11", waddr, 0); chk("R11", wcnt, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    cmd(8'h21, 8'h00);
    idle_check("R11", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule